// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It copies data items one at a time between a peripheral-side address and a memory-side address. Software programs the channel through a small register bus. It writes a control word, two base addresses and an item count, then sets the enable bit. Each transfer is one read beat from the source, followed by one write beat to the destination, on a single-beat bus master port. Each beat can be a byte, a halfword or a word.

In peripheral-paced mode, a transfer starts only when the request input is high. In memory-to-memory mode, transfers run back to back as soon as the channel is enabled. The channel keeps working pointers and a working count apart from the programmed values. Circular operation uses these to restart the block automatically. Status flags mark the halfway point, the end of the block and a bus error, and each flag has its own interrupt enable. The address, count and mode settings are locked while the channel is enabled or while a transfer is in flight.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, every register reads zero, `bus_req` is low and `irq` is low.
- R2: In peripheral-paced mode, a transfer starts only in a cycle where `dreq` is high, the channel is enabled and the count is nonzero. A transfer is a read beat followed by a write beat. `bus_req` stays high with a stable address until `bus_ack` or `bus_err` arrives. `xfer_done` is high in the cycle the write beat is acknowledged.
- R3: In memory-to-memory mode (control bit 6), transfers start without `dreq` and repeat until the count reaches zero.
- R4: With control bit 4 at 0, the source is the peripheral pointer and the destination is the memory pointer. With bit 4 at 1, the roles are swapped.
- R5: When a side's increment bit is set (bit 7 for the peripheral side, bit 8 for the memory side), its working pointer advances after each transfer. The step is 1, 2 or 4 for size codes 0, 1 and 2; code 3 steps by 4. The peripheral size is bits 10:9 and the memory size is bits 12:11. Base registers 1 and 2 never change. Registers 6 and 7 read the peripheral and memory working pointers.
- R6: The read data is kept only up to the source size. The write data is the held value cut down to the destination size, zero-extended from the least-significant bits. `bus_size` carries the size code of the beat.
- R7: Register 3 reads the remaining item count, which drops by one per completed transfer. A non-circular channel issues nothing once the count is zero. Enabling the channel with a zero count starts no transfer.
- R8: In circular mode (bit 5), the transfer that brings the count to zero reloads the programmed count and both base addresses into the working state, and the channel keeps running.
- R9: A control write with both bit 5 and bit 6 set stores memory-to-memory mode and clears circular mode. A write that sets only one of them clears the other.
- R10: While the enable bit (bit 0) is set or a transfer is in flight, writes to registers 1, 2 and 3 and to control bits 12:4 are ignored. Writes to bit 0 and to the interrupt enables (bits 1 to 3) still take effect.
- R11: Register 4 holds three flags: bit 0 is half, bit 1 is complete and bit 2 is error. Half sets when the remaining count first equals the programmed count shifted right by one. Complete sets when the count reaches zero. Writing 1 to a flag bit clears it, and a set in the same cycle wins over the clear.
- R12: `irq` is high whenever a flag is set and its enable is set. The enables are control bit 1 for half, bit 2 for complete and bit 3 for error.
- R13: A bus error in either beat sets the error flag and clears the enable bit. `bus_req` drops in the next cycle, and the count and pointers are left unchanged.
- R14: Clearing the enable bit keeps all register contents. Writing 1 to bit 0 of register 5 clears the control word, addresses, pointers, count and flags, and abandons any beat in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dreq | input | 1 | Peripheral transfer request |
| xfer_done | output | 1 | High while a transfer's write beat completes |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | AW | Beat address |
| bus_size | output | 2 | Beat size code: 0 byte, 1 halfword, 2 or 3 word |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Beat acknowledge |
| bus_err | input | 1 | Beat error response |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are events that land in the middle of a beat: a channel reset while a read beat is stalled, and a bus error while the request is held. The stimulus reaches them by gating the bus acknowledge, so a beat can be held open for as long as needed before the disturbing write or error arrives. Circular wrap needs the count to reach zero on an exact transfer. The stimulus counts completed transfers on `xfer_done` and drops the request right after the chosen one, so the working count and pointers can then be read at a known point in the wrap.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dreq,
  output logic          xfer_done,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic          irq
);
  typedef enum logic [1:0] {IDLE, RD, WR} st_t;
  st_t st;
  logic en, ie_h, ie_c, ie_e, dir, circ, m2m, pinc, minc;
  logic [1:0] psz, msz;
  logic [AW-1:0] pbase, mbase, pptr, mptr;
  logic [CW-1:0] prog, cnt;
  logic f_h, f_c, f_e;
  logic [31:0] hold;

  function automatic logic [31:0] szmask(input logic [1:0] s);
    case (s)
      2'd0: szmask = 32'h0000_00ff;
      2'd1: szmask = 32'h0000_ffff;
      default: szmask = 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic [AW-1:0] szstep(input logic [1:0] s, input logic inc);
    if (!inc) szstep = '0;
    else if (s == 2'd0) szstep = AW'(1);
    else if (s == 2'd1) szstep = AW'(2);
    else szstep = AW'(4);
  endfunction

  wire busy     = st != IDLE;
  wire lock     = en | busy;
  wire wr_ctl   = reg_wr && reg_addr == 3'd0;
  wire wr_pa    = reg_wr && reg_addr == 3'd1 && !lock;
  wire wr_ma    = reg_wr && reg_addr == 3'd2 && !lock;
  wire wr_cnt   = reg_wr && reg_addr == 3'd3 && !lock;
  wire wr_flg   = reg_wr && reg_addr == 3'd4;
  wire ch_rst   = reg_wr && reg_addr == 3'd5 && reg_wdata[0];
  wire [1:0] src_sz = dir ? msz : psz;
  wire [1:0] dst_sz = dir ? psz : msz;
  wire beat_err = busy && bus_err;
  wire start    = !busy && en && cnt != '0 && (m2m || dreq);
  wire [CW-1:0] cnt_nx = cnt - 1'b1;
  wire reload   = circ && cnt_nx == '0;

  assign xfer_done = st == WR && bus_ack && !bus_err;
  assign bus_req   = busy;
  assign bus_we    = st == WR;
  assign bus_addr  = ((st == WR) ^ dir) ? mptr : pptr;
  assign bus_size  = (st == WR) ? dst_sz : src_sz;
  assign bus_wdata = (st == WR) ? (hold & szmask(dst_sz)) : 32'd0;
  assign irq       = (f_h & ie_h) | (f_c & ie_c) | (f_e & ie_e);

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {19'd0, msz, psz, minc, pinc, m2m, circ, dir, ie_e, ie_c, ie_h, en};
      3'd1: reg_rdata = 32'(pbase);
      3'd2: reg_rdata = 32'(mbase);
      3'd3: reg_rdata = 32'(cnt);
      3'd4: reg_rdata = {29'd0, f_e, f_c, f_h};
      3'd6: reg_rdata = 32'(pptr);
      3'd7: reg_rdata = 32'(mptr);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || ch_rst) begin
      st <= IDLE;
      {en, ie_h, ie_c, ie_e, dir, circ, m2m, pinc, minc} <= '0;
      psz <= '0; msz <= '0;
      pbase <= '0; mbase <= '0; pptr <= '0; mptr <= '0;
      prog <= '0; cnt <= '0;
      {f_h, f_c, f_e} <= '0;
      hold <= '0;
    end else begin
      if (beat_err) en <= 1'b0;
      else if (wr_ctl) en <= reg_wdata[0];
      if (wr_ctl) begin
        {ie_e, ie_c, ie_h} <= reg_wdata[3:1];
        if (!lock) begin
          dir  <= reg_wdata[4];
          circ <= reg_wdata[5] & ~reg_wdata[6];
          m2m  <= reg_wdata[6];
          pinc <= reg_wdata[7];
          minc <= reg_wdata[8];
          psz  <= reg_wdata[10:9];
          msz  <= reg_wdata[12:11];
        end
      end
      if (wr_pa) begin pbase <= reg_wdata[AW-1:0]; pptr <= reg_wdata[AW-1:0]; end
      if (wr_ma) begin mbase <= reg_wdata[AW-1:0]; mptr <= reg_wdata[AW-1:0]; end
      if (wr_cnt) begin prog <= reg_wdata[CW-1:0]; cnt <= reg_wdata[CW-1:0]; end
      if (xfer_done) begin
        cnt  <= reload ? prog : cnt_nx;
        pptr <= reload ? pbase : pptr + szstep(psz, pinc);
        mptr <= reload ? mbase : mptr + szstep(msz, minc);
      end
      f_h <= (xfer_done && cnt_nx == (prog >> 1)) | (f_h & ~(wr_flg & reg_wdata[0]));
      f_c <= (xfer_done && cnt_nx == '0)          | (f_c & ~(wr_flg & reg_wdata[1]));
      f_e <= beat_err                             | (f_e & ~(wr_flg & reg_wdata[2]));
      case (st)
        IDLE: if (start) st <= RD;
        RD: begin
          if (beat_err) st <= IDLE;
          else if (bus_ack) begin
            hold <= bus_rdata & szmask(src_sz);
            st   <= WR;
          end
        end
        WR: if (beat_err || bus_ack) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  // R2
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err && !ch_rst) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
  // R13
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err && !ch_rst) |=> (!en && !bus_req));
  // R10
  base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ch_rst) |=> ($stable(pbase) && $stable(mbase) && $stable(prog)));
  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bus_req && cnt == '0) |=> !bus_req);
  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !circ && !ch_rst) |=> (cnt == $past(cnt) - 1'b1));
  // R8
  circ_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && circ && cnt == CW'(1) && !ch_rst) |=> (cnt == prog && pptr == pbase && mptr == mbase));
endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
  logic clk = 0, rst_n = 1;
  always #5 clk = ~clk;

  logic reg_wr = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, bus_addr, bus_wdata, bus_rdata;
  logic dreq = 0, xfer_done, bus_req, bus_we, bus_ack, bus_err, irq;
  logic [1:0] bus_size;
  logic ack_ok = 1, err_inj = 0, stall_on = 0;
  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] last_wa = 0, last_wd = 0;

  function automatic logic [31:0] rdpat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  assign bus_ack   = bus_req && ack_ok;
  assign bus_err   = bus_req && err_inj;
  assign bus_rdata = rdpat(bus_addr);

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dreq(dreq), .xfer_done(xfer_done), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_en, m_ih, m_ic, m_ie, m_dir, m_circ, m_m2m, m_pinc, m_minc, m_fh, m_fc, m_fe;
  int m_psz, m_msz, m_prog, m_cnt, m_ph;
  logic [31:0] m_pb, m_mb, m_pp, m_mp, m_buf;

  function automatic logic [31:0] mmask(input int s);
    return s == 0 ? 32'hFF : s == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] mstep(input int s, input bit inc);
    return !inc ? 0 : s == 0 ? 1 : s == 1 ? 2 : 4;
  endfunction

  task automatic mreset();
    {m_en, m_ih, m_ic, m_ie, m_dir, m_circ, m_m2m, m_pinc, m_minc, m_fh, m_fc, m_fe} = '0;
    m_psz = 0; m_msz = 0; m_prog = 0; m_cnt = 0; m_ph = 0;
    m_pb = 0; m_mb = 0; m_pp = 0; m_mp = 0; m_buf = 0;
  endtask

  task automatic mstep_cycle();
    bit busy = m_ph != 0;
    bit ack = busy && ack_ok;
    bit er = busy && err_inj;
    bit dn = m_ph == 2 && ack && !er;
    bit lk = m_en || busy;
    bit st = !busy && m_en && m_cnt != 0 && (m_m2m || dreq);
    int nx = (m_cnt - 1) & 16'hFFFF;
    logic [31:0] wd = reg_wdata;
    int ssz = m_dir ? m_msz : m_psz;
    logic [31:0] src = m_dir ? m_mp : m_pp;
    if (reg_wr && reg_addr == 5 && wd[0]) begin mreset(); return; end
    if (er) m_en = 0; else if (reg_wr && reg_addr == 0) m_en = wd[0];
    if (reg_wr && reg_addr == 0) begin
      m_ih = wd[1]; m_ic = wd[2]; m_ie = wd[3];
      if (!lk) begin
        m_dir = wd[4]; m_m2m = wd[6]; m_circ = wd[5] && !wd[6];
        m_pinc = wd[7]; m_minc = wd[8]; m_psz = int'(wd[10:9]); m_msz = int'(wd[12:11]);
      end
    end
    if (reg_wr && !lk && reg_addr == 1) begin m_pb = wd; m_pp = wd; end
    if (reg_wr && !lk && reg_addr == 2) begin m_mb = wd; m_mp = wd; end
    if (reg_wr && !lk && reg_addr == 3) begin m_prog = int'(wd[15:0]); m_cnt = m_prog; end
    if (reg_wr && reg_addr == 4) begin
      if (wd[0]) m_fh = 0; if (wd[1]) m_fc = 0; if (wd[2]) m_fe = 0;
    end
    if (dn) begin
      if (nx == m_prog / 2) m_fh = 1;
      if (nx == 0) m_fc = 1;
      if (m_circ && nx == 0) begin m_cnt = m_prog; m_pp = m_pb; m_mp = m_mb; end
      else begin m_cnt = nx; m_pp += mstep(m_psz, m_pinc); m_mp += mstep(m_msz, m_minc); end
    end
    if (er) m_fe = 1;
    if (m_ph == 0) begin if (st) m_ph = 1; end
    else if (er) m_ph = 0;
    else if (ack) begin
      if (m_ph == 1) begin m_buf = rdpat(src) & mmask(ssz); m_ph = 2; end
      else m_ph = 0;
    end
  endtask

  task automatic compare();
    int dsz = m_dir ? m_psz : m_msz;
    int ssz = m_dir ? m_msz : m_psz;
    logic [31:0] ea = (m_ph == 2) ? (m_dir ? m_pp : m_mp) : (m_dir ? m_mp : m_pp);
    logic [31:0] erd;
    case (reg_addr)
      0: erd = {19'd0, 2'(m_msz), 2'(m_psz), m_minc, m_pinc, m_m2m, m_circ, m_dir, m_ie, m_ic, m_ih, m_en};
      1: erd = m_pb; 2: erd = m_mb; 3: erd = 32'(m_cnt);
      4: erd = {29'd0, m_fe, m_fc, m_fh};
      6: erd = m_pp; 7: erd = m_mp;
      default: erd = 0;
    endcase
    check(bus_req == (m_ph != 0), "R2 model bus_req", 32'(bus_req), 32'(m_ph != 0));
    check(xfer_done == (m_ph == 2 && ack_ok && !err_inj), "R2 model xfer_done", 32'(xfer_done),
          32'(m_ph == 2 && ack_ok && !err_inj));
    if (m_ph != 0) begin
      check(bus_we == (m_ph == 2), "R4 model bus_we", 32'(bus_we), 32'(m_ph == 2));
      check(bus_addr == ea, "R4 model bus_addr", bus_addr, ea);
      check(bus_size == 2'(m_ph == 2 ? dsz : ssz), "R6 model bus_size", 32'(bus_size), 32'(m_ph == 2 ? dsz : ssz));
    end
    if (m_ph == 2) check(bus_wdata == (m_buf & mmask(dsz)), "R6 model bus_wdata", bus_wdata, m_buf & mmask(dsz));
    check(irq == ((m_fh && m_ih) || (m_fc && m_ic) || (m_fe && m_ie)), "R12 model irq", 32'(irq),
          32'((m_fh && m_ih) || (m_fc && m_ic) || (m_fe && m_ie)));
    check(reg_rdata == erd, "R7 model reg_rdata", reg_rdata, erd);
  endtask

  initial mreset();
  always @(posedge clk) begin
    if (xfer_done) begin last_wa = bus_addr; last_wd = bus_wdata; end
    if (!rst_n) mreset(); else mstep_cycle();
    #1 compare();
  end

  always @(negedge clk) begin
    cyc++;
    if (stall_on) ack_ok = (cyc % 3) != 0;
  end

  // ---------------- directed stimulus ----------------
  function automatic logic [31:0] ctl(bit e, bit ih, bit ic, bit ie, bit dr, bit ci, bit mm,
                                      bit pi, bit mi, logic [1:0] ps, logic [1:0] ms);
    return {19'd0, ms, ps, mi, pi, mm, ci, dr, ie, ic, ih, e};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic run_n(input int n);
    int k = 0;
    @(negedge clk); dreq = 1;
    while (k < n) begin
      @(negedge clk); #1;
      if (xfer_done) k++;
    end
    dreq = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] c;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 8; i++) expect_reg(3'(i), 0, "R1 reset register");
    check(bus_req == 0, "R1 reset bus_req", 32'(bus_req), 0);
    check(irq == 0, "R1 reset irq", 32'(irq), 0);

    // peripheral paced, byte source to word memory
    wr(1, 32'h12AB); wr(2, 32'h2000); wr(3, 5);
    c = ctl(1, 1, 1, 0, 0, 0, 0, 0, 1, 2'd0, 2'd2);
    wr(0, c);
    repeat (20) @(negedge clk);
    expect_reg(3, 5, "R2 no transfer without dreq");
    wr(1, 32'hDEAD0000); expect_reg(1, 32'h12AB, "R10 locked peripheral base");
    wr(3, 9);            expect_reg(3, 5, "R10 locked count");
    wr(0, ctl(1, 1, 1, 0, 1, 0, 0, 0, 1, 2'd2, 2'd2));
    expect_reg(0, c, "R10 locked mode bits");
    run_n(2);
    expect_reg(3, 3, "R7 remaining count");
    expect_reg(4, 0, "R11 half not yet");
    run_n(1);
    expect_reg(4, 1, "R11 half at floor(prog/2)");
    check(irq == 1, "R12 irq from half", 32'(irq), 1);
    run_n(2);
    expect_reg(4, 3, "R11 complete flag");
    expect_reg(3, 0, "R7 count zero");
    expect_reg(7, 32'h2014, "R5 memory pointer word step");
    expect_reg(6, 32'h12AB, "R5 peripheral pointer fixed");
    expect_reg(1, 32'h12AB, "R5 base unchanged");
    check(last_wa == 32'h2010, "R4 write to memory side", last_wa, 32'h2010);
    check(last_wd == 32'hAB, "R6 byte zero-extended", last_wd, 32'hAB);
    @(negedge clk); dreq = 1;
    repeat (10) @(negedge clk);
    check(bus_req == 0, "R7 stopped at zero", 32'(bus_req), 0);
    dreq = 0;
    wr(4, 1); expect_reg(4, 2, "R11 write-one clear");
    wr(4, 7); expect_reg(4, 0, "R11 clear all");
    check(irq == 0, "R12 irq low", 32'(irq), 0);
    wr(0, c & ~32'd1);
    expect_reg(2, 32'h2000, "R14 disable keeps base");
    expect_reg(7, 32'h2014, "R14 disable keeps pointer");

    // memory to memory, memory source, wait states
    wr(1, 32'h3000); wr(2, 32'h4000); wr(3, 3);
    stall_on = 1;
    wr(0, ctl(1, 0, 0, 0, 1, 0, 1, 1, 1, 2'd1, 2'd3));
    repeat (60) @(negedge clk);
    stall_on = 0; ack_ok = 1;
    expect_reg(3, 0, "R3 free-running to zero");
    expect_reg(6, 32'h3006, "R5 halfword step");
    expect_reg(7, 32'h400C, "R5 size code 3 steps by 4");
    expect_reg(4, 3, "R11 flags after m2m");
    check(last_wa == 32'h3004, "R4 reversed direction", last_wa, 32'h3004);
    check(last_wd == 32'h4008, "R6 truncated to halfword", last_wd, 32'h4008);
    wr(0, 0);

    // R9 exclusion
    wr(0, ctl(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0)); expect_reg(0, 32'h40, "R9 both set keeps m2m");
    wr(0, ctl(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0)); expect_reg(0, 32'h20, "R9 circular clears m2m");

    // circular
    wr(4, 7);
    wr(1, 32'h5000); wr(2, 32'h6000); wr(3, 2);
    wr(0, ctl(1, 0, 1, 0, 0, 1, 0, 1, 1, 2'd1, 2'd1));
    run_n(2);
    expect_reg(3, 2, "R8 count reloaded");
    expect_reg(7, 32'h6000, "R8 memory pointer reloaded");
    expect_reg(6, 32'h5000, "R8 peripheral pointer reloaded");
    expect_reg(4, 3, "R11 flags at wrap");
    run_n(3);
    expect_reg(3, 1, "R8 keeps running");
    expect_reg(7, 32'h6002, "R8 pointer after wrap");
    wr(0, 0);

    // R14 channel reset
    wr(5, 1);
    for (int i = 0; i < 8; i++) expect_reg(3'(i), 0, "R14 channel reset clears");

    // R13 bus error
    wr(1, 32'h7000); wr(2, 32'h8000); wr(3, 4);
    @(negedge clk); err_inj = 1;
    wr(0, ctl(1, 0, 0, 1, 0, 0, 1, 0, 1, 0, 0));
    repeat (10) @(negedge clk);
    check(bus_req == 0, "R13 request dropped", 32'(bus_req), 0);
    err_inj = 0;
    expect_reg(0, ctl(0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 0), "R13 enable cleared");
    expect_reg(4, 4, "R13 error flag");
    check(irq == 1, "R12 irq from error", 32'(irq), 1);
    expect_reg(3, 4, "R13 count unchanged");
    expect_reg(7, 32'h8000, "R13 pointer unchanged");

    // R7 zero count at enable
    wr(4, 7); wr(3, 0);
    wr(0, ctl(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    check(bus_req == 0, "R7 zero count no transfer", 32'(bus_req), 0);
    expect_reg(4, 0, "R7 no flags with zero count");

    // R14 reset during stalled beat
    wr(0, ctl(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
    wr(3, 8);
    @(negedge clk); ack_ok = 0;
    wr(0, ctl(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    check(bus_req == 1, "R2 beat held while stalled", 32'(bus_req), 1);
    wr(5, 1);
    check(bus_req == 0, "R14 reset abandons beat", 32'(bus_req), 0);
    expect_reg(3, 0, "R14 count cleared");
    expect_reg(0, 0, "R14 control cleared");
    ack_ok = 1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule